// File: doc/BRIEF.md
# Battery-Backed Seconds Counter with Scratch Memory

This block is a serial slave that keeps a 32-bit seconds count and a small bank of retained scratch words. A host drives it over a four-wire, mode-0 style serial link. Each access has two parts. First comes a 32-bit command word that carries a write flag and a register address. Then comes a 32-bit data word. In the data word the host either supplies the value to store or clocks out the value the block returns. Chip select may go high between the two words and the latched command survives.

The address space is sparse. It holds the counter, sixteen scratch words, a snapshot register that freezes the counter for a consistent read, two timer registers, four fixed test words and two control words. One scratch word is reserved by convention for a software bias, which is added to the counter outside the block. The first control word is read-only and mirrors two power-status inputs: supply instability and a weak backup cell. The counter advances on a one-cycle enable that the system asserts once per second.

Top module: `rtc_sram_slave`

## Requirements
- R1: After synchronous reset, the counter, snapshot, both timers and the second control word read as zero, `miso` is 0 and the block expects a command word.
- R2: Bits are sampled from `mosi` MSB first on rising `sck` while `cs_n` is low. In a command word, bit 31 set means write, bits 30:8 are the register address and bits 7:0 are ignored.
- R3: After a read command, the next 32-bit transfer shifts the addressed value out on `miso` MSB first. Bit 31 is valid before the first rising `sck`, and later bits change after each falling `sck`. The value is captured one clock after the command word completes.
- R4: The counter (0x200000) increments by one in every clock cycle where `tick_1hz` is high, and wraps from 0xFFFFFFFF to 0.
- R5: A write to 0x200000 loads the counter. If the write lands in the same cycle as a tick, the written value is kept and that tick is lost.
- R6: Scratch words 0x200001 through 0x200010 are readable and writable, and each holds its own value. Word 0x200004 is the bias slot.
- R7: A write to the snapshot register (0x204000) ignores its data and stores the counter value held before that cycle's tick. The stored value then stays fixed while the counter runs.
- R8: The on-timer (0x210000), off-timer (0x210001) and second control word (0x21000D) are full 32-bit read/write registers.
- R9: Test words 0x210004 to 0x210007 read as TEST_BASE OR (address − 0x210004), and writes to them are ignored.
- R10: Control word 0x21000C is read-only. Bit 11 shows `pwr_unstable`, bit 9 shows `batt_low` and all other bits are 0.
- R11: Reads of unmapped addresses return 0. Writes to unmapped addresses change no register or scratch word.
- R12: Raising `cs_n` discards any partial word but keeps the phase and the latched command, so a data word may follow in a later select.
- R13: `miso` stays 0 throughout command words and throughout the data word of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial pins are sampled on it |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle seconds enable |
| pwr_unstable | input | 1 | Supply instability flag |
| batt_low | input | 1 | Weak backup cell flag |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idle low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Registered serial data to host |

## Verification
Two functions can fall in the same clock. The first is the completing edge of a data word that writes the counter or the snapshot. The second is a seconds tick. The bench raises `tick_1hz` in the same cycle it raises the 32nd `sck` of that data word. It then reads back both registers. It expects the written counter value with no increment. For the snapshot case, it expects the pre-tick count in the snapshot and the post-tick count in the counter.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 24;

  localparam logic [ADDR_W-1:0] A_CNT   = 24'h200000;
  localparam logic [ADDR_W-1:0] A_SNAP  = 24'h204000;
  localparam logic [ADDR_W-1:0] A_TON   = 24'h210000;
  localparam logic [ADDR_W-1:0] A_TOFF  = 24'h210001;
  localparam logic [ADDR_W-1:0] A_TEST0 = 24'h210004;
  localparam logic [ADDR_W-1:0] A_CTL0  = 24'h21000C;
  localparam logic [ADDR_W-1:0] A_CTL1  = 24'h21000D;

  localparam int TEST_REGS = 4;
  localparam int FLAG_PWR_BIT  = 11;
  localparam int FLAG_BATT_BIT = 9;

  typedef enum logic {PH_CMD = 1'b0, PH_DATA = 1'b1} phase_e;
endpackage

// File: rtl/rtc_serial_port.sv
module rtc_serial_port #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sck,
  input  logic         cs_n,
  input  logic         mosi,
  input  logic         load_en,
  input  logic [W-1:0] load_data,
  output logic         word_done,
  output logic [W-1:0] word,
  output logic         miso
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          sck_d;
  logic [CW-1:0] bit_cnt;
  logic [W-1:0]  rx_sh;
  logic [W-1:0]  tx_sh;
  logic          miso_q;
  logic          rise, fall;

  assign rise      = !cs_n && sck && !sck_d;
  assign fall      = !cs_n && !sck && sck_d;
  assign word_done = rise && (bit_cnt == LAST);
  assign word      = {rx_sh[W-2:0], mosi};
  assign miso      = miso_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d   <= 1'b0;
      bit_cnt <= '0;
      rx_sh   <= '0;
    end else begin
      sck_d <= sck;
      if (cs_n) begin
        bit_cnt <= '0;
      end else if (rise) begin
        rx_sh   <= {rx_sh[W-2:0], mosi};
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
      end
    end
  end

  // shift-out only on falls that follow a rise inside the current word
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh  <= '0;
      miso_q <= 1'b0;
    end else if (load_en) begin
      miso_q <= load_data[W-1];
      tx_sh  <= {load_data[W-2:0], 1'b0};
    end else if (fall && bit_cnt != '0) begin
      miso_q <= tx_sh[W-1];
      tx_sh  <= {tx_sh[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/rtc_cmd_ctrl.sv
module rtc_cmd_ctrl
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word,
  output phase_e            phase,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_data,
  output logic              load_en,
  output logic              load_rd
);
  logic cmd_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_CMD;
      cmd_wr   <= 1'b0;
      cmd_addr <= '0;
      load_en  <= 1'b0;
      load_rd  <= 1'b0;
    end else begin
      load_en <= 1'b0;
      load_rd <= 1'b0;
      if (word_done) begin
        load_en <= 1'b1;
        if (phase == PH_CMD) begin
          cmd_wr   <= word[WORD_W-1];
          cmd_addr <= {1'b0, word[WORD_W-2:8]};
          load_rd  <= !word[WORD_W-1];
          phase    <= PH_DATA;
        end else begin
          phase <= PH_CMD;
        end
      end
    end
  end

  assign wr_en   = word_done && (phase == PH_DATA) && cmd_wr;
  assign wr_data = word;
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int          SRAM_WORDS = 16,
  parameter logic [31:0] TEST_BASE  = 32'h5E00_0000,
  localparam int         IW         = $clog2(SRAM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              pwr_unstable,
  input  logic              batt_low,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IW-1:0]     sram_ridx,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] cnt
);
  localparam logic [ADDR_W-1:0] SRAM_LO = A_CNT + 24'd1;
  localparam logic [ADDR_W-1:0] SRAM_HI = A_CNT + ADDR_W'(SRAM_WORDS);
  localparam logic [ADDR_W-1:0] TEST_HI = A_TEST0 + ADDR_W'(TEST_REGS - 1);

  logic [WORD_W-1:0] mem [SRAM_WORDS];
  logic [WORD_W-1:0] sram_q;
  logic [WORD_W-1:0] snap, ton, toff, ctl1;
  logic [WORD_W-1:0] test_val [TEST_REGS];
  logic [WORD_W-1:0] ctl0;
  logic [IW-1:0]     widx;
  logic              w_sram;

  function automatic logic in_sram(input logic [ADDR_W-1:0] a);
    return (a >= SRAM_LO) && (a <= SRAM_HI);
  endfunction

  assign w_sram = wr_en && in_sram(wr_addr);
  assign widx   = IW'(wr_addr - SRAM_LO);

  // simple dual-port scratch memory, registered read
  always_ff @(posedge clk) begin
    if (w_sram) mem[widx] <= wr_data;
    sram_q <= mem[sram_ridx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      snap <= '0;
      ton  <= '0;
      toff <= '0;
      ctl1 <= '0;
    end else begin
      if (wr_en && wr_addr == A_CNT) cnt <= wr_data;
      else if (tick)                 cnt <= cnt + 32'd1;
      if (wr_en && wr_addr == A_SNAP) snap <= cnt;
      if (wr_en && wr_addr == A_TON)  ton  <= wr_data;
      if (wr_en && wr_addr == A_TOFF) toff <= wr_data;
      if (wr_en && wr_addr == A_CTL1) ctl1 <= wr_data;
    end
  end

  for (genvar g = 0; g < TEST_REGS; g++) begin : g_test
    assign test_val[g] = TEST_BASE | 32'(g);
  end

  always_comb begin
    ctl0 = '0;
    ctl0[FLAG_PWR_BIT]  = pwr_unstable;
    ctl0[FLAG_BATT_BIT] = batt_low;
  end

  always_comb begin
    rdata = '0;
    if (rd_addr == A_CNT)                             rdata = cnt;
    else if (in_sram(rd_addr))                        rdata = sram_q;
    else if (rd_addr == A_SNAP)                       rdata = snap;
    else if (rd_addr == A_TON)                        rdata = ton;
    else if (rd_addr == A_TOFF)                       rdata = toff;
    else if (rd_addr >= A_TEST0 && rd_addr <= TEST_HI) rdata = test_val[rd_addr[1:0]];
    else if (rd_addr == A_CTL0)                       rdata = ctl0;
    else if (rd_addr == A_CTL1)                       rdata = ctl1;
  end
endmodule

// File: rtl/rtc_sram_slave.sv
module rtc_sram_slave
  import rtc_pkg::*;
#(
  parameter int          SRAM_WORDS = 16,
  parameter logic [31:0] TEST_BASE  = 32'h5E00_0000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_1hz,
  input  logic pwr_unstable,
  input  logic batt_low,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  localparam int IW = $clog2(SRAM_WORDS);

  logic              word_done;
  logic [WORD_W-1:0] word;
  phase_e            phase;
  logic [ADDR_W-1:0] cmd_addr;
  logic [ADDR_W-1:0] pre_addr;
  logic [IW-1:0]     sram_ridx;
  logic              wr_en;
  logic [WORD_W-1:0] wr_data;
  logic              load_en, load_rd;
  logic [WORD_W-1:0] rdata, load_data, cnt;

  assign pre_addr  = {1'b0, word[WORD_W-2:8]};
  assign sram_ridx = IW'(pre_addr - A_CNT - 24'd1);
  assign load_data = load_rd ? rdata : '0;

  rtc_serial_port #(.W(WORD_W)) u_port (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .load_en(load_en), .load_data(load_data),
    .word_done(word_done), .word(word), .miso(miso)
  );

  rtc_cmd_ctrl u_ctrl (
    .clk(clk), .rst(rst), .word_done(word_done), .word(word),
    .phase(phase), .cmd_addr(cmd_addr), .wr_en(wr_en), .wr_data(wr_data),
    .load_en(load_en), .load_rd(load_rd)
  );

  rtc_regfile #(.SRAM_WORDS(SRAM_WORDS), .TEST_BASE(TEST_BASE)) u_regs (
    .clk(clk), .rst(rst), .tick(tick_1hz),
    .pwr_unstable(pwr_unstable), .batt_low(batt_low),
    .wr_en(wr_en), .wr_addr(cmd_addr), .wr_data(wr_data),
    .sram_ridx(sram_ridx), .rd_addr(cmd_addr),
    .rdata(rdata), .cnt(cnt)
  );
endmodule

// File: rtl/rtc_sram_slave_chk.sv
module rtc_sram_slave_chk
  import rtc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              cs_n,
  input logic              word_done,
  input logic              in_data,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic              load_en,
  input logic [WORD_W-1:0] cnt
);
  logic cnt_wr;
  assign cnt_wr = wr_en && (cmd_addr == A_CNT);

  a_r4_count_up: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_wr) |=> (cnt == $past(cnt) + 32'd1));

  a_r4_count_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_wr) |=> (cnt == $past(cnt)));

  a_r5_write_wins: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt == $past(wr_data)));

  a_r3_load_after_cmd: assert property (@(posedge clk) disable iff (rst)
    (word_done && !in_data) |=> load_en);

  a_r12_cmd_kept: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> $stable(cmd_addr));

  a_r13_no_write_in_cmd: assert property (@(posedge clk) disable iff (rst)
    !in_data |-> !wr_en);
endmodule

bind rtc_sram_slave rtc_sram_slave_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick_1hz), .cs_n(cs_n),
  .word_done(word_done), .in_data(phase == rtc_pkg::PH_DATA),
  .cmd_addr(cmd_addr), .wr_en(wr_en), .wr_data(wr_data),
  .load_en(load_en), .cnt(cnt)
);

// File: tb/sim_rtc_sram_slave.sv
`timescale 1ns/1ps
module sim_rtc_sram_slave;
  localparam logic [31:0] TBASE = 32'h5E00_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1hz = 1'b0, pwr_unstable = 1'b0, batt_low = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  rtc_sram_slave #(.SRAM_WORDS(16), .TEST_BASE(TBASE)) u0 (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .pwr_unstable(pwr_unstable),
    .batt_low(batt_low), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] tx, input bit tick_last, output logic [31:0] rx);
    cs_n = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 31; i >= 0; i--) begin
      mosi = tx[i];
      repeat (4) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      if (tick_last && i == 0) tick_1hz = 1'b1;
      @(negedge clk);
      tick_1hz = 1'b0;
      repeat (3) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d, input bit tick_last = 1'b0);
    logic [31:0] r;
    xfer({1'b1, a[22:0], 8'h3C}, 1'b0, r);
    chk("R13 miso in write command", r, 32'h0);
    xfer(d, tick_last, r);
    chk("R13 miso in write data", r, 32'h0);
  endtask

  task automatic rd(input logic [23:0] a, output logic [31:0] d, input logic [7:0] lo = 8'hA7);
    logic [31:0] r;
    xfer({1'b0, a[22:0], lo}, 1'b0, r);
    xfer(32'hFFFF_FFFF, 1'b0, d);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_1hz = 1'b1; @(negedge clk);
      tick_1hz = 1'b0; @(negedge clk);
    end
  endtask

  function automatic logic [31:0] spat(input int i);
    return (32'h1000_0001 * (i + 1)) ^ 32'hA5C3_0F96;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [23:0] unm [8];
    unm[0] = 24'h200011; unm[1] = 24'h200012; unm[2] = 24'h204001; unm[3] = 24'h210002;
    unm[4] = 24'h210003; unm[5] = 24'h210008; unm[6] = 24'h21000E; unm[7] = 24'h000000;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 miso after reset", {31'b0, miso}, 32'h0);
    rd(24'h200000, v); chk("R1 counter reset", v, 32'h0);
    rd(24'h204000, v); chk("R1 snapshot reset", v, 32'h0);
    rd(24'h210000, v); chk("R1 on-timer reset", v, 32'h0);
    rd(24'h210001, v); chk("R1 off-timer reset", v, 32'h0);
    rd(24'h21000D, v); chk("R1 ctl1 reset", v, 32'h0);

    // R6 scratch sweep
    for (int i = 0; i < 16; i++) wr(24'h200001 + 24'(i), spat(i));
    for (int i = 0; i < 16; i++) begin
      rd(24'h200001 + 24'(i), v); chk("R6 scratch word", v, spat(i));
    end

    // R8 timers and ctl1
    wr(24'h210000, 32'h0BAD_F00D); wr(24'h210001, 32'h7654_3210); wr(24'h21000D, 32'hCAFE_0123);
    rd(24'h210000, v); chk("R8 on-timer", v, 32'h0BAD_F00D);
    rd(24'h210001, v); chk("R8 off-timer", v, 32'h7654_3210);
    rd(24'h21000D, v); chk("R8 ctl1", v, 32'hCAFE_0123);

    // R4 ticking and wrap, R5 load
    wr(24'h200000, 32'd100);
    rd(24'h200000, v); chk("R5 counter load", v, 32'd100);
    ticks(7);
    rd(24'h200000, v); chk("R4 counter ticks", v, 32'd107);
    wr(24'h200000, 32'hFFFF_FFFE);
    ticks(3);
    rd(24'h200000, v); chk("R4 counter wrap", v, 32'h1);

    // R5 write and tick in the same cycle
    wr(24'h200000, 32'h1234_5678, 1'b1);
    rd(24'h200000, v); chk("R5 write beats tick", v, 32'h1234_5678);

    // R7 snapshot with coincident tick
    wr(24'h200000, 32'h500);
    ticks(2);
    wr(24'h204000, 32'hDEAD_BEEF, 1'b1);
    rd(24'h204000, v); chk("R7 snapshot pre-tick value", v, 32'h502);
    rd(24'h200000, v); chk("R7 counter after coincident tick", v, 32'h503);
    ticks(4);
    rd(24'h204000, v); chk("R7 snapshot frozen", v, 32'h502);
    rd(24'h200000, v); chk("R4 counter runs on", v, 32'h507);

    // R9 test words
    for (int i = 0; i < 4; i++) begin
      rd(24'h210004 + 24'(i), v); chk("R9 test word", v, TBASE | 32'(i));
      wr(24'h210004 + 24'(i), 32'hFFFF_FFFF);
      rd(24'h210004 + 24'(i), v); chk("R9 test word after write", v, TBASE | 32'(i));
    end

    // R10 status flags
    for (int f = 0; f < 4; f++) begin
      pwr_unstable = f[1]; batt_low = f[0];
      rd(24'h21000C, v);
      chk("R10 ctl0 flags", v, (32'(f[1]) << 11) | (32'(f[0]) << 9));
    end
    pwr_unstable = 1'b0; batt_low = 1'b0;
    wr(24'h21000C, 32'hFFFF_FFFF);
    rd(24'h21000C, v); chk("R10 ctl0 ignores write", v, 32'h0);
    rd(24'h21000D, v); chk("R10 ctl1 untouched", v, 32'hCAFE_0123);

    // R11 unmapped
    for (int i = 0; i < 8; i++) begin
      wr(unm[i], 32'hFFFF_FFFF);
      rd(unm[i], v); chk("R11 unmapped reads zero", v, 32'h0);
    end
    for (int i = 0; i < 16; i++) begin
      rd(24'h200001 + 24'(i), v); chk("R11 scratch intact", v, spat(i));
    end
    rd(24'h210000, v); chk("R11 on-timer intact", v, 32'h0BAD_F00D);
    rd(24'h210001, v); chk("R11 off-timer intact", v, 32'h7654_3210);
    rd(24'h200000, v); chk("R11 counter intact", v, 32'h507);
    rd(24'h204000, v); chk("R11 snapshot intact", v, 32'h502);

    // R2 low command byte ignored
    rd(24'h200004, v, 8'hFF); chk("R2 low byte ignored (bias slot)", v, spat(3));
    rd(24'h200010, v, 8'h00); chk("R2 last scratch word", v, spat(15));

    // R12 partial word discarded, gap between phases
    cs_n = 1'b0; repeat (2) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      mosi = 1'b1; repeat (4) @(negedge clk);
      sck = 1'b1; repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk); cs_n = 1'b1; repeat (4) @(negedge clk);
    rd(24'h210001, v); chk("R12 partial word discarded", v, 32'h7654_3210);
    xfer({1'b0, 23'h200007, 8'h11}, 1'b0, v);
    repeat (60) @(negedge clk);
    xfer(32'h0, 1'b0, v); chk("R12 command kept across deselect", v, spat(6));
    chk("R13 miso idle after data phase", {31'b0, miso}, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule